// File: doc/BRIEF.md
# Three-Input Multiplexer Logic Element

This block is a small configurable logic cell. Three single-bit inputs each pass through a programmable inverter, so each one reaches the core either as it is or inverted. One of the three conditioned inputs is then chosen as the top-level select. Of the other two, the lower-numbered input is called `p` and the higher-numbered input is called `q`.

When the select is 0, the cell drives a 4-entry table indexed by `{q,p}`. When the select is 1, the cell drives a narrower 2:1 multiplexer. That multiplexer is steered by `p`, and each of its two legs is a constant or `q`. The narrower leg cannot form a two-input parity. Because of that, the cell can reach every three-input truth table except the two three-input parity functions.

A mode bit turns the cell into a level-sensitive latch built around a feedback path. In this mode:
- `in_a`, after its programmable inversion, is the data input.
- `in_b` opens the latch while it is high.
- `in_c` clears the latch and takes priority over `in_b`.

The cell drives two outputs with the same value: one feeds neighbouring cells and one feeds long routing. All configuration inputs are expected to be static while the cell is in use.

Top module: `mle_cell`

## Requirements
- R1: Each input `in_a`, `in_b`, `in_c` is XORed with bit 0, 1 and 2 of `cfg_inv`, giving the conditioned literals `l0`, `l1`, `l2`.
- R2: `cfg_role` picks the select literal `s` and the pair (`p`,`q`), in ascending input order. Code 1: `s=l1`, `p=l0`, `q=l2`. Code 2: `s=l2`, `p=l0`, `q=l1`. Codes 0 and 3: `s=l0`, `p=l1`, `q=l2`.
- R3: In logic mode (`cfg_latch`=0) with `s`=0, the output is `cfg_lut[{q,p}]`.
- R4: In logic mode with `s`=1, the output is `p ? H : L`. `H` is taken from `cfg_hi_src` and `L` from `cfg_lo_src`, where code 0 gives 0, code 1 gives 1, and codes 2 and 3 give `q`.
- R5: Over all configurations in logic mode, the set of truth tables reached has exactly 254 members. The truth-table bit at index `{in_c,in_b,in_a}` holds the output. Neither 8'h96 (odd parity) nor 8'h69 (even parity) is in the set.
- R6: In latch mode (`cfg_latch`=1) with `in_c`=0 and `in_b`=1, the output follows `l0`.
- R7: In latch mode with `in_c`=0 and `in_b`=0, the output holds its last value whatever `in_a` does.
- R8: In latch mode with `in_c`=1, the output is 0 regardless of `in_a` and `in_b`.
- R9: `out_local` and `out_long` always carry the same value.
- R10: While in logic mode, the stored latch value is not updated by `in_b` or `in_c`. On return to latch mode with `in_b`=`in_c`=0, the output shows the value stored before leaving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_a | input | 1 | Logic input 1; latch data in latch mode |
| in_b | input | 1 | Logic input 2; latch enable (high = open) in latch mode |
| in_c | input | 1 | Logic input 3; latch clear (high = clear) in latch mode |
| cfg_inv | input | 3 | Per-input inversion select, bit i for input i |
| cfg_role | input | 2 | Chooses which literal drives the top select |
| cfg_lut | input | 4 | Table used when the select literal is 0 |
| cfg_hi_src | input | 2 | Source of the narrow-leg data when `p`=1 |
| cfg_lo_src | input | 2 | Source of the narrow-leg data when `p`=0 |
| cfg_latch | input | 1 | 1 = latch mode, 0 = logic mode |
| out_local | output | 1 | Output to neighbouring cells |
| out_long | output | 1 | Output to long routing, same value as out_local |

## Verification
The bench walks every configuration through all eight input points and builds the set of reachable truth tables. A network whose narrow leg could form a parity would add 8'h96 or 8'h69 to that set. A swapped `p`/`q` order or a wrong role decode would change the set size or mismatch the per-point reference. Directed latch sequences target four behaviours:
- a clear asserted while the enable is high, which a latch with the wrong priority would let through as data;
- data toggling while the enable is low, which a latch that leaks would follow;
- an inverted data literal, which a cell that skips the inversion in latch mode would get wrong;
- a detour through logic mode, which would expose a storage element that keeps listening outside latch mode.

// File: rtl/mle_pkg.sv
// Shared constants and types for the three-input multiplexer logic element.
package mle_pkg;
    localparam int NUM_IN   = 3;
    localparam int TBL_W    = 1 << (NUM_IN - 1);
    localparam int TT_W     = 1 << NUM_IN;
    localparam int ROLE_W   = 2;
    localparam int SRC_W    = 2;

    // Data source code for one leg of the narrow multiplexer
    typedef enum logic [SRC_W-1:0] {
        SRC_ZERO = 2'd0,
        SRC_ONE  = 2'd1,
        SRC_LIT  = 2'd2,
        SRC_LITB = 2'd3
    } src_e;
endpackage

// File: rtl/mle_polarity.sv
// Programmable inversion stage: every input leaves either true or complemented.
// Assumes the inversion selects are static configuration.
module mle_polarity #(
    parameter int N = 3
) (
    input  logic [N-1:0] raw,
    input  logic [N-1:0] inv,
    output logic [N-1:0] lit
);
    for (genvar i = 0; i < N; i++) begin : g_pol
        // Conditional inversion of input i
        assign lit[i] = raw[i] ^ inv[i];
    end
endmodule

// File: rtl/mle_mux_net.sv
// Core multiplexer network. One literal selects between a full table of the
// other two literals and a restricted 2:1 mux whose legs are constants or q.
// Assumes all configuration is static; purely combinational.
module mle_mux_net
    import mle_pkg::*;
(
    input  logic [NUM_IN-1:0] lit,
    input  logic [ROLE_W-1:0] role,
    input  logic [TBL_W-1:0]  lut,
    input  logic [SRC_W-1:0]  hi_src,
    input  logic [SRC_W-1:0]  lo_src,
    output logic              f
);
    logic sel_lit, p_lit, q_lit;
    logic leg_hi, leg_lo, narrow, wide;

    // Decode a leg source code into its data value
    function automatic logic pick(input logic [SRC_W-1:0] code, input logic qv);
        case (src_e'(code))
            SRC_ZERO: pick = 1'b0;
            SRC_ONE:  pick = 1'b1;
            default:  pick = qv;
        endcase
    endfunction

    // Route literals to the select, p and q roles
    always_comb begin
        case (role)
            2'd1:    begin sel_lit = lit[1]; p_lit = lit[0]; q_lit = lit[2]; end
            2'd2:    begin sel_lit = lit[2]; p_lit = lit[0]; q_lit = lit[1]; end
            default: begin sel_lit = lit[0]; p_lit = lit[1]; q_lit = lit[2]; end
        endcase
    end

    // Build the two branches and the final select
    always_comb begin
        wide   = lut[{q_lit, p_lit}];
        leg_hi = pick(hi_src, q_lit);
        leg_lo = pick(lo_src, q_lit);
        narrow = p_lit ? leg_hi : leg_lo;
        f      = sel_lit ? narrow : wide;
    end
endmodule

// File: rtl/mle_latch_fb.sv
// Level-sensitive storage closed through the element's feedback path.
// Clear wins over open; nothing changes while en is low.
module mle_latch_fb (
    input  logic en,
    input  logic d,
    input  logic gate,
    input  logic clr,
    output logic q
);
    // Transparent-high latch with dominant clear
    always_latch begin
        if (en && clr)
            q <= 1'b0;
        else if (en && gate)
            q <= d;
    end
endmodule

// File: rtl/mle_cell.sv
// Three-input multiplexer logic element. Logic mode realises any three-input
// function except odd/even parity; latch mode uses in_b as enable and in_c as
// clear. Both outputs carry the same value. Assumes static configuration.
module mle_cell
    import mle_pkg::*;
(
    input  logic                 in_a,
    input  logic                 in_b,
    input  logic                 in_c,
    input  logic [NUM_IN-1:0]    cfg_inv,
    input  logic [ROLE_W-1:0]    cfg_role,
    input  logic [TBL_W-1:0]     cfg_lut,
    input  logic [SRC_W-1:0]     cfg_hi_src,
    input  logic [SRC_W-1:0]     cfg_lo_src,
    input  logic                 cfg_latch,
    output logic                 out_local,
    output logic                 out_long
);
    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] lit;
    logic              comb_f;
    logic              held;
    logic              result;

    // Gather the logic inputs into one vector
    assign raw_in = {in_c, in_b, in_a};

    mle_polarity #(.N(NUM_IN)) u_pol (
        .raw (raw_in),
        .inv (cfg_inv),
        .lit (lit)
    );

    mle_mux_net u_net (
        .lit    (lit),
        .role   (cfg_role),
        .lut    (cfg_lut),
        .hi_src (cfg_hi_src),
        .lo_src (cfg_lo_src),
        .f      (comb_f)
    );

    mle_latch_fb u_lat (
        .en   (cfg_latch),
        .d    (lit[0]),
        .gate (in_b),
        .clr  (in_c),
        .q    (held)
    );

    // Mode select between logic result and stored value
    assign result    = cfg_latch ? held : comb_f;
    // Fan the result to both drivers
    assign out_local = result;
    assign out_long  = result;
endmodule

// File: rtl/mle_cell_chk.sv
// Checker for mle_cell: evaluates the configured function over all eight
// points and checks reachability, logic-mode output, latch rules and outputs.
module mle_cell_chk
    import mle_pkg::*;
(
    input  logic                 in_a,
    input  logic                 in_b,
    input  logic                 in_c,
    input  logic [NUM_IN-1:0]    cfg_inv,
    input  logic [ROLE_W-1:0]    cfg_role,
    input  logic [TBL_W-1:0]     cfg_lut,
    input  logic [SRC_W-1:0]     cfg_hi_src,
    input  logic [SRC_W-1:0]     cfg_lo_src,
    input  logic                 cfg_latch,
    input  logic                 out_local,
    input  logic                 out_long
);
    logic [TT_W-1:0] tt;

    // Shannon form of the configured function at one input point
    function automatic logic point(input logic [2:0] x);
        logic [2:0] l;
        logic s, p, q, h, lo;
        l = x ^ cfg_inv;
        s = (cfg_role == 2'd1) ? l[1] : (cfg_role == 2'd2) ? l[2] : l[0];
        p = (cfg_role == 2'd0 || cfg_role == 2'd3) ? l[1] : l[0];
        q = (cfg_role == 2'd2) ? l[1] : l[2];
        h  = (cfg_hi_src[1]) ? q : cfg_hi_src[0];
        lo = (cfg_lo_src[1]) ? q : cfg_lo_src[0];
        point = s ? (p ? h : lo) : cfg_lut[{q, p}];
    endfunction

    // Truth table of the current configuration
    always_comb begin
        for (int k = 0; k < TT_W; k++) tt[k] = point(3'(k));
    end

    // Immediate checks on settled combinational values
    always_comb begin
        a_r9_outputs_agree: assert (out_local == out_long);
        if (!cfg_latch) begin
            a_r5_no_parity: assert (tt != 8'h96 && tt != 8'h69);
            a_r3_r4_logic_value: assert (out_local == tt[{in_c, in_b, in_a}]);
        end
        if (cfg_latch && in_c) begin
            a_r8_clear_wins: assert (out_local == 1'b0);
        end
        if (cfg_latch && in_b && !in_c) begin
            a_r6_transparent: assert (out_local == (in_a ^ cfg_inv[0]));
        end
    end
endmodule

bind mle_cell mle_cell_chk u_chk (.*);

// File: tb/mle_cell_tb.sv
module mle_cell_tb;
    localparam int CLK_PERIOD   = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic clk = 1'b0;
    logic in_a, in_b, in_c;
    logic [2:0] cfg_inv;
    logic [1:0] cfg_role;
    logic [3:0] cfg_lut;
    logic [1:0] cfg_hi_src, cfg_lo_src;
    logic cfg_latch;
    logic out_local, out_long;

    int n_cmp = 0;
    int n_bad = 0;
    logic model_q = 1'b0;
    logic [255:0] reach = '0;
    logic [7:0] tt;

    always #(CLK_PERIOD/2) clk = ~clk;

    mle_cell u_dut (
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .cfg_inv(cfg_inv), .cfg_role(cfg_role), .cfg_lut(cfg_lut),
        .cfg_hi_src(cfg_hi_src), .cfg_lo_src(cfg_lo_src),
        .cfg_latch(cfg_latch),
        .out_local(out_local), .out_long(out_long)
    );

    // Expected logic-mode value, written from R1 to R4
    function automatic logic ref_logic(input logic [2:0] inv, input logic [1:0] role,
                                       input logic [3:0] lut, input logic [1:0] hs,
                                       input logic [1:0] ls, input logic [2:0] x);
        logic [2:0] l;
        logic s, p, q, hv, lv;
        l = x ^ inv;
        case (role)
            2'd1: begin s = l[1]; p = l[0]; q = l[2]; end
            2'd2: begin s = l[2]; p = l[0]; q = l[1]; end
            default: begin s = l[0]; p = l[1]; q = l[2]; end
        endcase
        hv = (hs == 2'd0) ? 1'b0 : (hs == 2'd1) ? 1'b1 : q;
        lv = (ls == 2'd0) ? 1'b0 : (ls == 2'd1) ? 1'b1 : q;
        return s ? (p ? hv : lv) : lut[2*q + p];
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive inputs, let them settle, update the latch model and compare
    task automatic step(input logic [2:0] x, input string req);
        logic e;
        {in_c, in_b, in_a} = x;
        #2;
        if (cfg_latch) begin
            if (x[2]) model_q = 1'b0;
            else if (x[1]) model_q = x[0] ^ cfg_inv[0];
            e = model_q;
        end else begin
            e = ref_logic(cfg_inv, cfg_role, cfg_lut, cfg_hi_src, cfg_lo_src, x);
        end
        check(out_local === e, req, int'(out_local), int'(e));
        check(out_long === out_local, "R9", int'(out_long), int'(out_local));
        #2;
    endtask

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        cfg_inv = 3'b000; cfg_role = 2'd0; cfg_lut = 4'h0;
        cfg_hi_src = 2'd0; cfg_lo_src = 2'd0; cfg_latch = 1'b1;
        {in_c, in_b, in_a} = 3'b000;
        #1;
        // Initial clear state (R8)
        step(3'b100, "R8 initial clear");
        step(3'b111, "R8 clear beats open");
        // Transparent and hold (R6, R7)
        step(3'b011, "R6 open passes 1");
        step(3'b000, "R7 hold with data low");
        step(3'b001, "R7 hold with data high");
        step(3'b010, "R6 open passes 0");
        step(3'b001, "R7 hold 0");
        // Inverted data literal in latch mode (R1, R6)
        cfg_inv = 3'b001;
        step(3'b010, "R1 R6 inverted data");
        // Logic-mode detour leaves storage alone (R10)
        cfg_latch = 1'b0;
        step(3'b110, "R10 logic mode");
        step(3'b011, "R10 logic mode");
        cfg_latch = 1'b1;
        step(3'b000, "R10 value kept across modes");
        cfg_inv = 3'b000;

        // Exhaustive logic-mode sweep (R1-R4 per point, R5 set)
        cfg_latch = 1'b0;
        for (int iv = 0; iv < 8; iv++)
            for (int ro = 0; ro < 3; ro++)
                for (int lu = 0; lu < 16; lu++)
                    for (int hs = 0; hs < 4; hs++)
                        for (int ls = 0; ls < 4; ls++) begin
                            cfg_inv = 3'(iv); cfg_role = 2'(ro); cfg_lut = 4'(lu);
                            cfg_hi_src = 2'(hs); cfg_lo_src = 2'(ls);
                            for (int k = 0; k < 8; k++) begin
                                step(3'(k), "R2 R3 R4 sweep");
                                tt[k] = out_local;
                            end
                            reach[tt] = 1'b1;
                        end
        check($countones(reach) == 254, "R5 reachable count", $countones(reach), 254);
        check(reach[8'h96] == 1'b0, "R5 odd parity absent", int'(reach[8'h96]), 0);
        check(reach[8'h69] == 1'b0, "R5 even parity absent", int'(reach[8'h69]), 0);
        check(reach[8'h80] == 1'b1, "R5 three-input AND present", int'(reach[8'h80]), 1);

        // Random mix including role code 3 (R2) and latch runs
        for (int n = 0; n < 3000; n++) begin
            cfg_inv = 3'($urandom); cfg_role = 2'($urandom); cfg_lut = 4'($urandom);
            cfg_hi_src = 2'($urandom); cfg_lo_src = 2'($urandom);
            if (($urandom % 4) == 0) begin
                cfg_latch = 1'b1;
                step(3'b100, "R8 random clear");
                for (int j = 0; j < 6; j++) step(3'($urandom), "R6 R7 R8 random latch");
            end else begin
                cfg_latch = 1'b0;
                step(3'($urandom), "R2 R3 R4 random logic");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule